// File: doc/BRIEF.md
# Host Interrupt Status Register

This block holds the 32-bit interrupt status word that a network controller shows to its host processor. It combines two kinds of bit. Sticky event bits latch a one-cycle trigger from the datapath and stay set until software writes a one to them. Live summary bits copy the pending levels that the switch fabric, the two PHY ports and the timestamp unit present, and software cannot write them. The dropped-frame halfway event is found inside the block by watching the dropped-frame counter value step across the middle of its range.

Software reads the word at one fixed register offset through a simple read port and clears events through a matching write port. The enable mask is an input that comes from a neighbouring register. It never hides a status bit. It only gates the single interrupt request line, which is registered once. The `rst_n` input is asynchronous, and the block releases it internally through a two-stage synchronizer.

Top module: `hif_irq_status`

## Requirements
- R1: After reset release, with all source inputs low, a read of the register returns 0 and `irq` is 0.
- R2: Bit 30 sets on a rising `dev_ready`. Bit 25 sets when `tx_stop_req` AND `tx_halted` rises. Bit 24 sets on a rising `rx_halted`. Bit 21 sets on a `tx_ioc` pulse and bit 20 on a `rx_dma_done` pulse. Each of these bits then stays set while its source stays unchanged.
- R3: A write to offset 0x058 clears every sticky bit (31, 30, 25, 24, 23, 21, 20) whose data bit is 1. Sticky bits written with 0 keep their value. A write to any other offset changes nothing.
- R4: When a set trigger and a write-1 clear reach the same bit in the same cycle, the bit ends up set.
- R5: Bit 31, the software interrupt, sets on a `soft_set` pulse and clears through R3.
- R6: Bits 29, 28, 27 and 26 show `ts_pend`, `fabric_pend`, `phy_pend[1]` and `phy_pend[0]` as sampled in the read cycle. Writes have no effect on them.
- R7: Bit 23 sets only when `drop_cnt` goes from 2^(DROP_W-1)-1 in one cycle to exactly 2^(DROP_W-1) in the next cycle. Any other jump across the midpoint does not set it.
- R8: Bit 22 and bits 19:0 always read 0, whatever is written.
- R9: Status bits show their state whatever `irq_mask` holds. `irq` equals the OR over all bits of (status AND `irq_mask`), taken one clock earlier.
- R10: `rd_data` is registered. One cycle after `rd_en` is high with `rd_addr` equal to 0x058, it holds the status word. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write offset |
| wr_data | input | 32 | Write data; a 1 clears a sticky bit |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W | Read offset |
| rd_data | output | 32 | Registered read data |
| irq_mask | input | 32 | Interrupt enable mask |
| soft_set | input | 1 | Pulse: software interrupt enable written high |
| dev_ready | input | 1 | Device ready level |
| tx_stop_req | input | 1 | Stop-transmit request level |
| tx_halted | input | 1 | Transmitter halted level |
| rx_halted | input | 1 | Receiver halted level |
| tx_ioc | input | 1 | Pulse: flagged TX buffer fully loaded |
| rx_dma_done | input | 1 | Pulse: programmed RX DMA count drained |
| drop_cnt | input | DROP_W | Dropped-frame counter value |
| ts_pend | input | 1 | Timestamp unit pending level |
| fabric_pend | input | 1 | Switch fabric pending level |
| phy_pend | input | 2 | PHY pending levels, [0] port 1, [1] port 2 |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with its defaults: a 12-bit offset, the register at 0x058, and a full 32-bit dropped-frame counter. The counter is an input, so the bench can drive the exact values 0x7FFFFFFF and 0x80000000 directly. It also drives near misses on both sides of the midpoint, which cover the only-this-step rule without counting up through the whole range. Held levels, set-versus-clear collisions and writes to the wrong offset are then exercised by directed cases and by a seeded random run near the counter midpoint.

// File: rtl/hif_irq_pkg.sv
package hif_irq_pkg;
  localparam int unsigned REG_W = 32;

  localparam int unsigned B_SOFT   = 31;
  localparam int unsigned B_READY  = 30;
  localparam int unsigned B_TS     = 29;
  localparam int unsigned B_FABRIC = 28;
  localparam int unsigned B_PHY2   = 27;
  localparam int unsigned B_PHY1   = 26;
  localparam int unsigned B_TXSTOP = 25;
  localparam int unsigned B_RXSTOP = 24;
  localparam int unsigned B_DROPH  = 23;
  localparam int unsigned B_TXIOC  = 21;
  localparam int unsigned B_RXDMA  = 20;

  // Bits software clears by writing one.
  localparam logic [REG_W-1:0] STICKY_MASK = 32'hC3B0_0000;
  // Bits that mirror sub-unit levels.
  localparam logic [REG_W-1:0] LIVE_MASK   = 32'h3C00_0000;
  // Every implemented bit.
  localparam logic [REG_W-1:0] IMPL_MASK   = STICKY_MASK | LIVE_MASK;
endpackage

// File: rtl/irq_rise_det.sv
module irq_rise_det #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst_q,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  for (genvar i = 0; i < W; i++) begin : g_lane
    always_ff @(posedge clk or negedge rst_q) begin
      if (!rst_q) prev_q[i] <= 1'b0;
      else        prev_q[i] <= lvl_i[i];
    end
    assign rise_o[i] = lvl_i[i] & ~prev_q[i];
  end
endmodule

// File: rtl/irq_half_cross.sv
module irq_half_cross #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_q,
  input  logic [W-1:0] cnt_i,
  output logic         cross_o
);
  localparam logic [W-1:0] MID   = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] BELOW = {1'b0, {(W-1){1'b1}}};

  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) prev_q <= '0;
    else        prev_q <= cnt_i;
  end

  assign cross_o = (prev_q == BELOW) && (cnt_i == MID);
endmodule

// File: rtl/irq_w1c_bank.sv
module irq_w1c_bank #(
  parameter int unsigned    W    = 32,
  parameter logic [W-1:0]   MASK = '1
) (
  input  logic         clk,
  input  logic         rst_q,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] st_o
);
  logic [W-1:0] st_q;
  logic [W-1:0] st_d;
  logic [W-1:0] en;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      en[i]   = (set_i[i] | clr_i[i]) & MASK[i];
      st_d[i] = set_i[i];
    end
    always_ff @(posedge clk or negedge rst_q) begin
      if (!rst_q)     st_q[i] <= 1'b0;
      else if (en[i]) st_q[i] <= st_d[i];
    end
  end

  assign st_o = st_q;
endmodule

// File: rtl/hif_irq_status.sv
module hif_irq_status
  import hif_irq_pkg::*;
#(
  parameter int unsigned        ADDR_W   = 12,
  parameter logic [ADDR_W-1:0]  REG_ADDR = 'h058,
  parameter int unsigned        DROP_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  input  logic [31:0]       irq_mask,
  input  logic              soft_set,
  input  logic              dev_ready,
  input  logic              tx_stop_req,
  input  logic              tx_halted,
  input  logic              rx_halted,
  input  logic              tx_ioc,
  input  logic              rx_dma_done,
  input  logic [DROP_W-1:0] drop_cnt,
  input  logic              ts_pend,
  input  logic              fabric_pend,
  input  logic [1:0]        phy_pend,
  output logic              irq
);
  localparam int unsigned N_LVL = 3;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_pipe;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  // Level sources that raise an event on their rising edge.
  logic [N_LVL-1:0] lvl;
  logic [N_LVL-1:0] rise;

  assign lvl = {rx_halted, tx_stop_req & tx_halted, dev_ready};

  irq_rise_det #(.W(N_LVL)) u_rise (
    .clk    (clk),
    .rst_q  (rst_q),
    .lvl_i  (lvl),
    .rise_o (rise)
  );

  logic drop_half;

  irq_half_cross #(.W(DROP_W)) u_half (
    .clk     (clk),
    .rst_q   (rst_q),
    .cnt_i   (drop_cnt),
    .cross_o (drop_half)
  );

  // Set and clear vectors for the sticky bank.
  logic        wr_hit;
  logic        rd_hit;
  logic [31:0] set_vec;
  logic [31:0] clr_vec;
  logic [31:0] sticky;
  logic [31:0] live;
  logic [31:0] view;

  assign wr_hit = wr_en && (wr_addr == REG_ADDR);
  assign rd_hit = rd_addr == REG_ADDR;

  always_comb begin
    set_vec           = '0;
    set_vec[B_SOFT]   = soft_set;
    set_vec[B_READY]  = rise[0];
    set_vec[B_TXSTOP] = rise[1];
    set_vec[B_RXSTOP] = rise[2];
    set_vec[B_DROPH]  = drop_half;
    set_vec[B_TXIOC]  = tx_ioc;
    set_vec[B_RXDMA]  = rx_dma_done;
  end

  always_comb begin
    clr_vec = '0;
    if (wr_hit) clr_vec = wr_data & STICKY_MASK;
  end

  irq_w1c_bank #(.W(REG_W), .MASK(STICKY_MASK)) u_bank (
    .clk   (clk),
    .rst_q (rst_q),
    .set_i (set_vec),
    .clr_i (clr_vec),
    .st_o  (sticky)
  );

  always_comb begin
    live           = '0;
    live[B_TS]     = ts_pend;
    live[B_FABRIC] = fabric_pend;
    live[B_PHY2]   = phy_pend[1];
    live[B_PHY1]   = phy_pend[0];
  end

  assign view = (sticky | live) & IMPL_MASK;

  // Output registers.
  logic [31:0] rd_d;
  logic        irq_d;

  always_comb begin
    rd_d  = (rd_en && rd_hit) ? view : '0;
    irq_d = |(view & irq_mask);
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      rd_data <= '0;
      irq     <= 1'b0;
    end else begin
      rd_data <= rd_d;
      irq     <= irq_d;
    end
  end
endmodule

// File: rtl/hif_irq_status_chk.sv
module hif_irq_status_chk
  import hif_irq_pkg::*;
(
  input logic        clk,
  input logic        rst_q,
  input logic        wr_hit,
  input logic [31:0] wr_data,
  input logic [31:0] set_vec,
  input logic [31:0] sticky,
  input logic [31:0] irq_mask,
  input logic        irq,
  input logic        rd_en,
  input logic        rd_hit,
  input logic [31:0] rd_data,
  input logic        fabric_pend,
  input logic        soft_set
);
  // R3
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (wr_hit && |(wr_data & STICKY_MASK & ~set_vec))
    |=> ((sticky & $past(wr_data & STICKY_MASK & ~set_vec)) == '0));

  // R3
  hold_without_write_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !wr_hit |=> ((sticky & $past(sticky)) == $past(sticky)));

  // R4
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (|set_vec) |=> ((sticky & $past(set_vec)) == $past(set_vec)));

  // R5
  soft_set_chk: assert property (@(posedge clk) disable iff (!rst_q)
    soft_set |=> sticky[B_SOFT]);

  // R6
  fabric_live_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (rd_en && rd_hit) |=> (rd_data[B_FABRIC] == $past(fabric_pend)));

  // R8
  unimpl_zero_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (rd_data & ~IMPL_MASK) == '0);

  // R9
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (|(sticky & irq_mask)) |=> irq);

  // R10
  idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !rd_en |=> (rd_data == '0));
endmodule

bind hif_irq_status hif_irq_status_chk u_chk (
  .clk         (clk),
  .rst_q       (rst_q),
  .wr_hit      (wr_hit),
  .wr_data     (wr_data),
  .set_vec     (set_vec),
  .sticky      (sticky),
  .irq_mask    (irq_mask),
  .irq         (irq),
  .rd_en       (rd_en),
  .rd_hit      (rd_hit),
  .rd_data     (rd_data),
  .fabric_pend (fabric_pend),
  .soft_set    (soft_set)
);

// File: tb/hif_irq_status_test.sv
`timescale 1ns/1ps
module hif_irq_status_test;
  localparam int unsigned ADDR_W = 12;
  localparam logic [ADDR_W-1:0] OFF = 12'h058;
  localparam logic [31:0] STK = 32'hC3B0_0000;
  localparam logic [31:0] IMP = 32'hFFB0_0000;
  localparam logic [31:0] BELOW = 32'h7FFF_FFFF;
  localparam logic [31:0] MID   = 32'h8000_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 0, rd_en = 0;
  logic [ADDR_W-1:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, irq_mask = '0, rd_data;
  logic soft_set = 0, dev_ready = 0, tx_stop_req = 0, tx_halted = 0;
  logic rx_halted = 0, tx_ioc = 0, rx_dma_done = 0;
  logic [31:0] drop_cnt = '0;
  logic ts_pend = 0, fabric_pend = 0;
  logic [1:0] phy_pend = '0;
  logic irq;

  always #10 clk = ~clk;

  hif_irq_status uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .irq_mask(irq_mask), .soft_set(soft_set), .dev_ready(dev_ready),
    .tx_stop_req(tx_stop_req), .tx_halted(tx_halted), .rx_halted(rx_halted),
    .tx_ioc(tx_ioc), .rx_dma_done(rx_dma_done), .drop_cnt(drop_cnt),
    .ts_pend(ts_pend), .fabric_pend(fabric_pend), .phy_pend(phy_pend),
    .irq(irq)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // Bench model of the sticky bits and the edge history.
  logic [31:0] m_st = '0;
  logic p_ready = 0, p_tx = 0, p_rx = 0;
  logic [31:0] p_cnt = '0;

  function automatic logic [31:0] live_bits();
    logic [31:0] v = '0;
    v[29] = ts_pend; v[28] = fabric_pend; v[27] = phy_pend[1]; v[26] = phy_pend[0];
    return v;
  endfunction

  function automatic logic [31:0] set_bits();
    logic [31:0] s = '0;
    s[31] = soft_set;
    s[30] = dev_ready & ~p_ready;
    s[25] = (tx_stop_req & tx_halted) & ~p_tx;
    s[24] = rx_halted & ~p_rx;
    s[23] = (p_cnt == BELOW) && (drop_cnt == MID);
    s[21] = tx_ioc;
    s[20] = rx_dma_done;
    return s;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Inputs are already driven; predict, clock once, compare.
  task automatic step(input string tag);
    logic [31:0] view, exp_rd, clr;
    logic exp_irq;
    view    = (m_st | live_bits()) & IMP;
    exp_rd  = (rd_en && rd_addr == OFF) ? view : 32'h0;
    exp_irq = |(view & irq_mask);
    clr     = (wr_en && wr_addr == OFF) ? (wr_data & STK) : 32'h0;
    m_st    = (m_st & ~clr) | set_bits();
    p_ready = dev_ready; p_tx = tx_stop_req & tx_halted; p_rx = rx_halted;
    p_cnt   = drop_cnt;
    @(negedge clk);
    check({tag, " rd_data"}, rd_data, exp_rd);
    check({tag, " irq"}, {31'b0, irq}, {31'b0, exp_irq});
  endtask

  task automatic quiet();
    soft_set = 0; tx_ioc = 0; rx_dma_done = 0; wr_en = 0; wr_data = '0; wr_addr = OFF;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rd_en = 1; rd_addr = OFF; irq_mask = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    step("R1"); step("R1");

    // R2: each trigger
    tx_ioc = 1; step("R2"); quiet(); step("R2");
    rx_dma_done = 1; step("R2"); quiet(); step("R2");
    dev_ready = 1; step("R2"); step("R2");
    tx_stop_req = 1; step("R2 stop req alone");
    tx_halted = 1; step("R2"); step("R2");
    rx_halted = 1; step("R2"); step("R2");

    // R3: write zero, wrong offset, selective and full clear
    wr_en = 1; wr_data = '0; step("R3 zero"); quiet(); step("R3");
    wr_en = 1; wr_addr = OFF + 12'h4; wr_data = '1; step("R3 other addr"); quiet(); step("R3");
    wr_en = 1; wr_data = 32'h0020_0000; step("R3 clear 21"); quiet(); step("R3");
    wr_en = 1; wr_data = '1; step("R3 clear all"); quiet(); step("R3 levels held");

    // R4: set and clear together
    tx_ioc = 1; wr_en = 1; wr_data = 32'h0020_0000; step("R4"); quiet(); step("R4");

    // R5: software interrupt
    soft_set = 1; step("R5"); quiet(); step("R5");
    wr_en = 1; wr_data = 32'h8000_0000; step("R5 clear"); quiet(); step("R5");

    // R6: live bits and writes to them
    ts_pend = 1; phy_pend = 2'b10; step("R6"); step("R6");
    fabric_pend = 1; phy_pend = 2'b01; wr_en = 1; wr_data = '1; step("R6 write"); quiet(); step("R6");
    ts_pend = 0; fabric_pend = 0; phy_pend = 0; step("R6"); step("R6");

    // R7: only the exact midpoint step
    drop_cnt = BELOW - 1; step("R7"); drop_cnt = MID; step("R7 skip"); step("R7");
    drop_cnt = BELOW; step("R7"); drop_cnt = MID + 1; step("R7 overshoot"); step("R7");
    drop_cnt = BELOW; step("R7"); drop_cnt = MID; step("R7 exact"); step("R7");

    // R8: unimplemented bits after writing ones
    wr_en = 1; wr_data = 32'h004F_FFFF; step("R8"); quiet(); step("R8");

    // R9: mask gates only the request
    tx_ioc = 1; step("R9"); quiet();
    irq_mask = '0; step("R9 masked"); step("R9 masked");
    irq_mask = 32'h0020_0000; step("R9 one bit"); step("R9");
    irq_mask = 32'h0010_0000; step("R9 other bit"); step("R9");
    irq_mask = '1;

    // R10: read port
    rd_addr = OFF + 12'h8; step("R10 other addr"); step("R10");
    rd_en = 0; rd_addr = OFF; step("R10 idle"); step("R10");
    rd_en = 1; step("R10"); step("R10");

    // Random run; covers R2..R10 together
    for (int i = 0; i < 3000; i++) begin
      soft_set    = ($urandom % 16) == 0;
      tx_ioc      = ($urandom % 8) == 0;
      rx_dma_done = ($urandom % 8) == 0;
      dev_ready   = ($urandom % 4) != 0 ? dev_ready : ~dev_ready;
      tx_stop_req = ($urandom % 4) != 0 ? tx_stop_req : ~tx_stop_req;
      tx_halted   = ($urandom % 4) != 0 ? tx_halted : ~tx_halted;
      rx_halted   = ($urandom % 4) != 0 ? rx_halted : ~rx_halted;
      ts_pend     = 1'($urandom); fabric_pend = 1'($urandom); phy_pend = 2'($urandom);
      drop_cnt    = ($urandom % 3 == 0) ? MID : (BELOW - 32'($urandom % 2));
      irq_mask    = ($urandom % 2) ? $urandom : '1;
      wr_en       = ($urandom % 4) == 0;
      wr_addr     = ($urandom % 5 == 0) ? OFF + 12'h4 : OFF;
      wr_data     = $urandom;
      rd_en       = ($urandom % 6) != 0;
      rd_addr     = ($urandom % 7 == 0) ? OFF - 12'h4 : OFF;
      step("R9 random");
    end

    done = 1;
    summary();
    $finish;
  end
endmodule